// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block takes a 64-bit request word written by one core to raise a software interrupt on other cores, together with the index of the core that wrote it and a flag that says whether that core may raise group 1 interrupts. It then walks the cores one per clock cycle, starting at core 0. For every core that the request selects, it sets the pending bit of the requested interrupt ID. The result is a sticky pending vector of 16 bits per core, which the interrupt delivery logic downstream consumes and clears.

A target is chosen in one of two ways. In the first, affinity levels 1 to 3 must equal those in the request, and the core's level-0 value must select a set bit in a 16-bit target list. A working copy of that list loses each bit once its core is found, and the walk ends early when the copy is empty. In the second, broadcast, every core except the requester is chosen. Each core's four affinity levels sit in a table loaded through a write port. A 16-bit group register assigns each interrupt ID to group 0 or group 1. A request is taken only while the block is idle. `busy` is high during the walk, and `done` pulses for one cycle once the walk is over.

Top module: `sgi_dispatch`

## Requirements
- R1: During reset and on the first cycle after it, `busy`, `done` and every bit of `pend` are 0. The affinity table and the group register reset to 0.
- R2: Request word fields are: target list at bits 15:0, affinity level 1 at 23:16, interrupt ID at 27:24, level 2 at 39:32, routing-mode bit at 40, level 3 at 55:48. When the routing-mode bit is 0, core c is a target only if its levels 1, 2 and 3 equal the request's and its level-0 value L0 is below 16 with list bit L0 set. In that case `pend[c*16+ID]` is set.
- R3: Each target in routing mode 0 clears its L0 bit from a working copy of the list, so a later core with the same affinity is not a target. The walk ends on the cycle that empties the copy, or after the last core. `busy` stays high for one cycle per core visited, and an empty list visits only core 0.
- R4: When the routing-mode bit is 1, every core except the one whose index is on `req_src` is a target. The walk visits all NUM_CORES cores.
- R5: Bit k of the group register (0 = group 0, 1 = group 1) gates ID k. A group 0 ID is always set on a target. A group 1 ID is set only if `req_g1_ok` was 1 when the request was taken.
- R6: `busy` rises on the cycle after a request is taken. `done` is high for exactly the one cycle after the last visit, and `busy` is low on that cycle.
- R7: A request presented while `busy` is high is ignored and sets no pending bit.
- R8: Pending bits stay set until `clr_en` clears bit `clr_id` of core `clr_core`. If a clear and a set hit the same bit in the same cycle, the bit ends up set.
- R9: When `aff_wr_en` is high, `aff_wr_val` (level 0 in 7:0, level 1 in 15:8, level 2 in 23:16, level 3 in 31:24) is written to entry `aff_wr_idx`. The new value is used for visits from the next cycle on.
- R10: A core whose level-0 value is 16 or more is never a target in routing mode 0, even when the low four bits of that value select a set list bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_word | input | 64 | Request word |
| req_src | input | IDX_W | Index of requesting core |
| req_g1_ok | input | 1 | Requester may raise group 1 |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| aff_wr_en | input | 1 | Affinity table write strobe |
| aff_wr_idx | input | IDX_W | Affinity entry to write |
| aff_wr_val | input | 32 | Affinity levels 3..0, 8 bits each |
| grp_wr_en | input | 1 | Group register write strobe |
| grp_wr_val | input | 16 | Group per ID (1 = group 1) |
| clr_en | input | 1 | Pending clear strobe |
| clr_core | input | IDX_W | Core whose bit is cleared |
| clr_id | input | 4 | ID whose bit is cleared |
| pend | output | NUM_CORES*16 | Pending bits, core c at c*16+ID |

## Verification
The assertions take for granted that `rst_n` is asserted for at least one clock before the first request. They also assume `req_src` names a core that exists. When `NUM_CORES` is not a power of two, an out-of-range index would never match the broadcast exclusion. The stimulus loads the affinity table and the group register only while the block is idle, and it keeps `req_src` inside the core range. One request is deliberately held high through a walk to exercise the ignore rule. A clear hits a live bit between walks.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

    localparam int REQ_W    = 64;
    localparam int ID_W     = 4;
    localparam int NUM_IDS  = 1 << ID_W;
    localparam int LIST_W   = 16;
    localparam int LVL_W    = 8;
    localparam int AFF_W    = 4 * LVL_W;
    localparam int AFF_HI_W = 3 * LVL_W;

    typedef struct packed {
        logic [LVL_W-1:0]  lvl3;
        logic [LVL_W-1:0]  lvl2;
        logic [LVL_W-1:0]  lvl1;
        logic [LVL_W-1:0]  lvl0;
    } sgi_aff_t;

    typedef struct packed {
        logic [LVL_W-1:0]  lvl3;
        logic [LVL_W-1:0]  lvl2;
        logic [LVL_W-1:0]  lvl1;
        logic              bcast;
        logic [ID_W-1:0]   id;
        logic [LIST_W-1:0] list;
    } sgi_req_t;

    // Pull the fields of a request word out of their fixed bit positions.
    function automatic sgi_req_t sgi_decode(input logic [REQ_W-1:0] w);
        sgi_req_t r;
        r.list  = w[15:0];
        r.lvl1  = w[23:16];
        r.id    = w[27:24];
        r.lvl2  = w[39:32];
        r.bcast = w[40];
        r.lvl3  = w[55:48];
        return r;
    endfunction

endpackage

// File: rtl/sgi_aff_table.sv
module sgi_aff_table
    import sgi_pkg::*;
#(
    parameter int NUM_CORES = 8,
    localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  sgi_aff_t         wr_val,
    input  logic [IDX_W-1:0] rd_idx,
    output sgi_aff_t         rd_val
);

    sgi_aff_t ent_d [NUM_CORES];
    sgi_aff_t ent_q [NUM_CORES];

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_ent
        always_comb begin
            ent_d[c] = ent_q[c];
            if (wr_en && (wr_idx == IDX_W'(c))) begin
                ent_d[c] = wr_val;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[c] <= '0;
            end else begin
                ent_q[c] <= ent_d[c];
            end
        end
    end

    always_comb begin
        rd_val = '0;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (rd_idx == IDX_W'(c)) begin
                rd_val = ent_q[c];
            end
        end
    end

endmodule

// File: rtl/sgi_target_match.sv
module sgi_target_match
    import sgi_pkg::*;
#(
    parameter int NUM_CORES = 8,
    localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  sgi_aff_t            cand_aff,
    input  logic [IDX_W-1:0]    cand_idx,
    input  logic [AFF_HI_W-1:0] want_hi,
    input  logic                bcast,
    input  logic [IDX_W-1:0]    src_idx,
    input  logic [LIST_W-1:0]   mask,
    output logic                hit,
    output logic [LIST_W-1:0]   mask_next
);

    logic                  hi_eq;
    logic                  lo_ok;
    logic [LIST_W-1:0]     lo_bit;

    always_comb begin
        hi_eq  = ({cand_aff.lvl3, cand_aff.lvl2, cand_aff.lvl1} == want_hi);
        lo_ok  = (cand_aff.lvl0 < LVL_W'(LIST_W));
        lo_bit = lo_ok ? (LIST_W'(1) << cand_aff.lvl0[ID_W-1:0]) : '0;

        if (bcast) begin
            hit = (cand_idx != src_idx);
        end else begin
            hit = hi_eq && ((mask & lo_bit) != '0);
        end

        mask_next = (hit && !bcast) ? (mask & ~lo_bit) : mask;
    end

endmodule

// File: rtl/sgi_pend_bank.sv
module sgi_pend_bank
    import sgi_pkg::*;
#(
    parameter int NUM_CORES = 8,
    localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        set_en,
    input  logic [IDX_W-1:0]            set_core,
    input  logic [ID_W-1:0]             set_id,
    input  logic                        clr_en,
    input  logic [IDX_W-1:0]            clr_core,
    input  logic [ID_W-1:0]             clr_id,
    output logic [NUM_CORES*NUM_IDS-1:0] pend
);

    logic [NUM_IDS-1:0] row_d [NUM_CORES];
    logic [NUM_IDS-1:0] row_q [NUM_CORES];

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_row
        logic [NUM_IDS-1:0] clr_vec;
        logic [NUM_IDS-1:0] set_vec;

        always_comb begin
            clr_vec = (clr_en && (clr_core == IDX_W'(c))) ? (NUM_IDS'(1) << clr_id) : '0;
            set_vec = (set_en && (set_core == IDX_W'(c))) ? (NUM_IDS'(1) << set_id) : '0;
            // a set in the same cycle overrides a clear of the same bit
            row_d[c] = (row_q[c] & ~clr_vec) | set_vec;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_q[c] <= '0;
            end else begin
                row_q[c] <= row_d[c];
            end
        end

        assign pend[c*NUM_IDS +: NUM_IDS] = row_q[c];
    end

endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter int NUM_CORES = 8,
    localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [REQ_W-1:0]             req_word,
    input  logic [IDX_W-1:0]             req_src,
    input  logic                         req_g1_ok,
    output logic                         busy,
    output logic                         done,
    input  logic                         aff_wr_en,
    input  logic [IDX_W-1:0]             aff_wr_idx,
    input  logic [AFF_W-1:0]             aff_wr_val,
    input  logic                         grp_wr_en,
    input  logic [NUM_IDS-1:0]           grp_wr_val,
    input  logic                         clr_en,
    input  logic [IDX_W-1:0]             clr_core,
    input  logic [ID_W-1:0]              clr_id,
    output logic [NUM_CORES*NUM_IDS-1:0] pend
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CORES - 1);

    typedef struct packed {
        logic                busy;
        logic                done;
        logic [IDX_W-1:0]    idx;
        logic [LIST_W-1:0]   mask;
        logic [ID_W-1:0]     id;
        logic                bcast;
        logic [IDX_W-1:0]    src;
        logic                g1ok;
        logic [AFF_HI_W-1:0] want_hi;
        logic [NUM_IDS-1:0]  grp;
    } scan_t;

    scan_t              s_d;
    scan_t              s_q;
    sgi_req_t           req;
    sgi_aff_t           cand_aff;
    logic               hit;
    logic [LIST_W-1:0]  mask_next;
    logic               set_en;
    logic               last_visit;

    assign req = sgi_decode(req_word);

    sgi_aff_table #(.NUM_CORES(NUM_CORES)) u_aff (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (aff_wr_en),
        .wr_idx (aff_wr_idx),
        .wr_val (sgi_aff_t'(aff_wr_val)),
        .rd_idx (s_q.idx),
        .rd_val (cand_aff)
    );

    sgi_target_match #(.NUM_CORES(NUM_CORES)) u_match (
        .cand_aff  (cand_aff),
        .cand_idx  (s_q.idx),
        .want_hi   (s_q.want_hi),
        .bcast     (s_q.bcast),
        .src_idx   (s_q.src),
        .mask      (s_q.mask),
        .hit       (hit),
        .mask_next (mask_next)
    );

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        set_en     = 1'b0;
        last_visit = 1'b0;

        if (grp_wr_en) begin
            s_d.grp = grp_wr_val;
        end

        if (s_q.busy) begin
            set_en     = hit && (!s_q.grp[s_q.id] || s_q.g1ok);
            s_d.mask   = mask_next;
            last_visit = (s_q.idx == LAST_IDX) || (!s_q.bcast && (mask_next == '0));
            if (last_visit) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end else if (req_valid) begin
            s_d.busy    = 1'b1;
            s_d.idx     = '0;
            s_d.mask    = req.list;
            s_d.id      = req.id;
            s_d.bcast   = req.bcast;
            s_d.src     = req_src;
            s_d.g1ok    = req_g1_ok;
            s_d.want_hi = {req.lvl3, req.lvl2, req.lvl1};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    sgi_pend_bank #(.NUM_CORES(NUM_CORES)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (set_en),
        .set_core (s_q.idx),
        .set_id   (s_q.id),
        .clr_en   (clr_en),
        .clr_core (clr_core),
        .clr_id   (clr_id),
        .pend     (pend)
    );

    assign busy = s_q.busy;
    assign done = s_q.done;

endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk
    import sgi_pkg::*;
#(
    parameter int NUM_CORES = 8,
    localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         busy,
    input logic                         done,
    input logic [NUM_CORES*NUM_IDS-1:0] pend,
    input logic                         set_en,
    input logic [IDX_W-1:0]             set_core,
    input logic                         bcast,
    input logic [IDX_W-1:0]             src,
    input logic                         g1ok,
    input logic                         grp_bit,
    input logic [LIST_W-1:0]            mask,
    input logic [IDX_W-1:0]             idx
);

    // R6: the end-of-walk pulse lasts one cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: the walk ending always raises done in the same cycle
    a_r6_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R6: done only follows a walk
    a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // R7: a pending bit can only appear as the result of a walk step
    a_r7_set_needs_walk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend)) != '0) |-> $past(busy));

    // R4: broadcast never marks the requester
    a_r4_skip_requester: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && bcast) |-> (set_core != src));

    // R5: group 1 IDs only with permission
    a_r5_group_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && grp_bit) |-> g1ok);

    // R3: the working list never gains bits during a walk
    a_r3_mask_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ((mask & ~$past(mask)) == '0));

    // R3: the walk visits one core per cycle in ascending order
    a_r3_idx_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (idx == IDX_W'($past(idx) + 1'b1)));

endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .pend     (pend),
    .set_en   (set_en),
    .set_core (s_q.idx),
    .bcast    (s_q.bcast),
    .src      (s_q.src),
    .g1ok     (s_q.g1ok),
    .grp_bit  (s_q.grp[s_q.id]),
    .mask     (s_q.mask),
    .idx      (s_q.idx)
);

// File: tb/sgi_dispatch_tb_top.sv
module sgi_dispatch_tb_top;

    localparam int NC = 8;
    localparam int IW = 3;
    localparam int NI = 16;

    logic              clk;
    logic              rst_n;
    logic              req_valid;
    logic [63:0]       req_word;
    logic [IW-1:0]     req_src;
    logic              req_g1_ok;
    logic              busy;
    logic              done;
    logic              aff_wr_en;
    logic [IW-1:0]     aff_wr_idx;
    logic [31:0]       aff_wr_val;
    logic              grp_wr_en;
    logic [NI-1:0]     grp_wr_val;
    logic              clr_en;
    logic [IW-1:0]     clr_core;
    logic [3:0]        clr_id;
    logic [NC*NI-1:0]  pend;

    sgi_dispatch #(.NUM_CORES(NC)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_word(req_word), .req_src(req_src), .req_g1_ok(req_g1_ok),
        .busy(busy), .done(done),
        .aff_wr_en(aff_wr_en), .aff_wr_idx(aff_wr_idx), .aff_wr_val(aff_wr_val),
        .grp_wr_en(grp_wr_en), .grp_wr_val(grp_wr_val),
        .clr_en(clr_en), .clr_core(clr_core), .clr_id(clr_id),
        .pend(pend)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    int    n_checks = 0;
    int    n_fail   = 0;
    string tag      = "R1";
    bit    finished = 0;

    task automatic check(input string t, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          m_busy, m_done, m_g1;
    int          m_vis, m_last, m_id;
    bit          m_hit [NC];
    logic [15:0] m_pend [NC];
    logic [15:0] m_grp;
    logic [31:0] m_aff [NC];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_grp = '0;
            foreach (m_pend[c]) begin m_pend[c] = '0; m_aff[c] = '0; end
        end else begin
            if (clr_en) m_pend[clr_core][clr_id] = 1'b0;
            m_done = 0;
            if (m_busy) begin
                if (m_hit[m_vis] && (!m_grp[m_id] || m_g1)) m_pend[m_vis][m_id] = 1'b1;
                if (m_vis == m_last) begin m_busy = 0; m_done = 1; end
                else m_vis++;
            end else if (req_valid) begin
                logic [15:0] lst;
                lst  = req_word[15:0];
                m_id = int'(req_word[27:24]);
                m_g1 = req_g1_ok;
                m_last = NC - 1;
                foreach (m_hit[c]) m_hit[c] = 0;
                if (req_word[40]) begin
                    foreach (m_hit[c]) m_hit[c] = (c != int'(req_src));
                end else if (lst == 0) begin
                    m_last = 0;
                end else begin
                    for (int c = 0; c < NC; c++) begin
                        int l0;
                        l0 = int'(m_aff[c][7:0]);
                        if (m_aff[c][31:8] == {req_word[55:48], req_word[39:32], req_word[23:16]}
                            && l0 < 16 && lst[l0]) begin
                            m_hit[c] = 1;
                            lst[l0] = 1'b0;
                            if (lst == 0) begin m_last = c; break; end
                        end
                    end
                end
                m_busy = 1; m_vis = 0;
            end
            if (grp_wr_en) m_grp = grp_wr_val;
            if (aff_wr_en) m_aff[aff_wr_idx] = aff_wr_val;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [NC*NI-1:0] exp_p;
            foreach (m_pend[c]) exp_p[c*NI +: NI] = m_pend[c];
            check({tag, " R6 busy"}, 128'(busy), 128'(m_busy));
            check({tag, " R6 done"}, 128'(done), 128'(m_done));
            check({tag, " pend"}, 128'(pend), 128'(exp_p));
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [63:0] mk(input logic [15:0] lst, input logic [7:0] l1,
                                       input logic [3:0] id, input logic [7:0] l2,
                                       input logic rm, input logic [7:0] l3);
        logic [63:0] w;
        w = '0;
        w[15:0] = lst; w[23:16] = l1; w[27:24] = id; w[39:32] = l2; w[40] = rm; w[55:48] = l3;
        return w;
    endfunction

    function automatic logic pb(input int core, input int id);
        return pend[core*NI + id];
    endfunction

    task automatic send(input logic [63:0] w, input int src, input logic g1, output int cyc);
        @(negedge clk);
        req_valid = 1; req_word = w; req_src = IW'(src); req_g1_ok = g1;
        @(negedge clk);
        req_valid = 0;
        cyc = 0;
        for (int k = 0; k < 100; k++) begin
            if (busy) cyc++;
            if (done) break;
            @(negedge clk);
        end
        @(negedge clk);
        check("R6 done one cycle", 128'(done), 128'(0));
    endtask

    int cyc;

    initial begin
        repeat (40000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; req_valid = 0; req_word = '0; req_src = '0; req_g1_ok = 0;
        aff_wr_en = 0; aff_wr_idx = '0; aff_wr_val = '0;
        grp_wr_en = 0; grp_wr_val = '0; clr_en = 0; clr_core = '0; clr_id = '0;
        repeat (3) @(negedge clk);
        check("R1 busy in reset", 128'(busy), 128'(0));
        check("R1 pend in reset", 128'(pend), 128'(0));
        rst_n = 1;
        @(negedge clk);
        check("R1 done after reset", 128'(done), 128'(0));

        // R9: load the affinity table: cluster c/4, level 0 = c%4, core 7 has level 0 = 20
        tag = "R9";
        for (int c = 0; c < NC; c++) begin
            aff_wr_en = 1; aff_wr_idx = IW'(c);
            aff_wr_val = {8'd0, 8'd0, 8'(c / 4), (c == 7) ? 8'd20 : 8'(c % 4)};
            @(negedge clk);
        end
        aff_wr_en = 0;

        // R2/R3: cluster 0, list bits 0 and 2, ID 3; walk stops at core 2
        tag = "R2";
        send(mk(16'h0005, 8'd0, 4'd3, 8'd0, 1'b0, 8'd0), 1, 1'b1, cyc);
        check("R2 core0 id3", 128'(pb(0, 3)), 128'(1));
        check("R2 core2 id3", 128'(pb(2, 3)), 128'(1));
        check("R2 core1 id3 untouched", 128'(pb(1, 3)), 128'(0));
        check("R3 early stop visits", 128'(cyc), 128'(3));

        // R3: list bit 3 has no owner, full walk
        tag = "R3";
        send(mk(16'h000A, 8'd1, 4'd5, 8'd0, 1'b0, 8'd0), 0, 1'b1, cyc);
        check("R3 core5 id5", 128'(pb(5, 5)), 128'(1));
        check("R3 full walk visits", 128'(cyc), 128'(NC));

        // R10: level 0 = 20 aliases bit 4 in its low bits, must not match
        tag = "R10";
        send(mk(16'h0010, 8'd1, 4'd6, 8'd0, 1'b0, 8'd0), 0, 1'b1, cyc);
        check("R10 core7 id6 not set", 128'(pb(7, 6)), 128'(0));

        // R2: level 2/3 mismatch gives nothing
        send(mk(16'h000F, 8'd0, 4'd4, 8'd1, 1'b0, 8'd0), 0, 1'b1, cyc);
        check("R2 level2 mismatch core0 id4", 128'(pb(0, 4)), 128'(0));

        // R4: broadcast from core 2
        tag = "R4";
        send(mk(16'h0000, 8'd0, 4'd7, 8'd0, 1'b1, 8'd0), 2, 1'b0, cyc);
        check("R4 requester skipped", 128'(pb(2, 7)), 128'(0));
        check("R4 core0 id7", 128'(pb(0, 7)), 128'(1));
        check("R4 core7 id7", 128'(pb(7, 7)), 128'(1));
        check("R4 visits", 128'(cyc), 128'(NC));

        // R5: ID 9 in group 1
        tag = "R5";
        @(negedge clk); grp_wr_en = 1; grp_wr_val = 16'h0200;
        @(negedge clk); grp_wr_en = 0;
        send(mk(16'h0000, 8'd0, 4'd9, 8'd0, 1'b1, 8'd0), 0, 1'b0, cyc);
        check("R5 group1 blocked", 128'(pb(3, 9)), 128'(0));
        send(mk(16'h0000, 8'd0, 4'd10, 8'd0, 1'b1, 8'd0), 0, 1'b0, cyc);
        check("R5 group0 always", 128'(pb(3, 10)), 128'(1));
        send(mk(16'h0000, 8'd0, 4'd9, 8'd0, 1'b1, 8'd0), 0, 1'b1, cyc);
        check("R5 group1 allowed", 128'(pb(3, 9)), 128'(1));

        // R7: second request held during a walk
        tag = "R7";
        @(negedge clk);
        req_valid = 1; req_word = mk(16'h0000, 8'd0, 4'd11, 8'd0, 1'b1, 8'd0);
        req_src = '0; req_g1_ok = 1;
        @(negedge clk);
        req_word = mk(16'h0000, 8'd0, 4'd12, 8'd0, 1'b1, 8'd0);
        repeat (3) @(negedge clk);
        req_valid = 0;
        while (!done) @(negedge clk);
        @(negedge clk);
        check("R7 first accepted", 128'(pb(1, 11)), 128'(1));
        check("R7 busy request ignored", 128'(pend & {NC{16'h1000}}), 128'(0));

        // R8: clear one bit, neighbours stay
        tag = "R8";
        clr_en = 1; clr_core = 3'd0; clr_id = 4'd3;
        @(negedge clk);
        clr_en = 0;
        check("R8 cleared", 128'(pb(0, 3)), 128'(0));
        check("R8 sticky neighbour", 128'(pb(2, 3)), 128'(1));

        // R8: clear and set of the same bit in one cycle, set wins (core 1 visited 2nd cycle)
        @(negedge clk);
        req_valid = 1; req_word = mk(16'h0000, 8'd0, 4'd3, 8'd0, 1'b1, 8'd0); req_src = 3'd7;
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        clr_en = 1; clr_core = 3'd1; clr_id = 4'd3;
        @(negedge clk);
        clr_en = 0;
        check("R8 set wins over clear", 128'(pb(1, 3)), 128'(1));
        while (!done) @(negedge clk);

        // R3: empty list visits only core 0
        tag = "R3";
        send(mk(16'h0000, 8'd0, 4'd13, 8'd0, 1'b0, 8'd0), 0, 1'b1, cyc);
        check("R3 empty list visits", 128'(cyc), 128'(1));
        check("R3 empty list no pend", 128'(pend & {NC{16'h2000}}), 128'(0));

        repeat (3) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule